// File: doc/BRIEF.md
# Dead-Zone-Free Phase-Frequency Detector

This block compares two edge streams inside a PLL: one from the reference divider and one from the feedback divider. Each edge arrives as a single-cycle pulse that is synchronous to a fast sampling clock. The block answers each edge with a pump request. A reference edge raises `up` and a feedback edge raises `dn`. The lead of one stream over the other therefore shows up as extra width on one request. Averaged over time, the difference `up` minus `dn` tracks the phase and frequency error between the two streams.

The block never lets a request rise and fall in the same instant. When both requests are high, a shared clear is started. That clear is held back by a programmable number of sampling-clock cycles, so the two requests always overlap for a minimum time. This overlap removes the dead zone around zero phase error. The overlap length comes from a 2-bit code. If a divider edge arrives while the clear is still pending, the block keeps it and applies it as soon as the clear completes.

Top module: `pfd_abp`

## Requirements
- R1: A synchronous active-high `rst` drives `up` and `dn` low on the next clock edge and discards any held edge and any partial overlap count.
- R2: A pulse on `ref_pulse` while `up` is low makes `up` high one cycle later. While `dn` is low, `up` stays high and further `ref_pulse` pulses have no effect on it.
- R3: A pulse on `fb_pulse` while `dn` is low makes `dn` high one cycle later. While `up` is low, `dn` stays high and further `fb_pulse` pulses have no effect on it.
- R4: Once `up` and `dn` are both high, they stay high together for exactly D cycles and then both go low on the same clock edge, unless a held edge re-raises one of them. Neither request ever falls while the other is low.
- R5: The overlap length D is `abp_sel` + 1 cycles, with `abp_sel` read as an unsigned 2-bit value: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R6: A `ref_pulse` or `fb_pulse` that arrives while both requests are high is held. On the cycle right after the overlap ends, the matching request is high.
- R7: When both pulses arrive in the same cycle, `up` and `dn` each go high for exactly D cycles.
- R8: When a reference pulse leads a feedback pulse by k cycles, `up` stays high for k + D cycles and `dn` stays high for D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Single-cycle reference divider edge |
| fb_pulse | input | 1 | Single-cycle feedback divider edge |
| abp_sel | input | 2 | Overlap length code (D = value + 1) |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |

## Verification
The bench applies in-phase pulse pairs under each of the four codes. A design with an off-by-one in the overlap counter would produce pulses one cycle too short or too long, and a design with no delay would give zero-width overlaps. The bench also sends edges into an active overlap. A design that dropped them would leave the request low after the clear, and a design that applied them at once would break the overlap early. Leading and lagging pulse pairs check that the lead adds to the width of only one request. A reset issued in the middle of an overlap checks that no stale count or held edge survives.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    // width of the overlap selection code
    parameter int ABP_W = 2;
    // number of detector channels (reference, feedback)
    parameter int N_CH  = 2;

    typedef struct packed {
        logic flag;
        logic pend;
    } flag_state_t;
endpackage

// File: rtl/pfd_edge_flag.sv
module pfd_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic both_i,
    input  logic done_i,
    output logic flag_o
);
    import pfd_pkg::*;

    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (done_i) begin
            // overlap ends: a held or fresh edge re-arms the flag
            s_d.flag = s_q.pend | edge_i;
            s_d.pend = 1'b0;
        end else if (both_i) begin
            // clear pending: keep any incoming edge for later
            s_d.pend = s_q.pend | edge_i;
        end else begin
            s_d.flag = s_q.flag | edge_i;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign flag_o = s_q.flag;
endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
    parameter int SEL_W = pfd_pkg::ABP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             both_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             done_o
);
    localparam int CNT_W = SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t t_d, t_q;
    logic         done;

    always_comb begin
        done = both_i && (t_q.cnt == CNT_W'(sel_i));
        t_d  = t_q;
        if (both_i && !done) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end else begin
            t_d.cnt = '0;
        end
        if (rst) begin
            t_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign done_o = done;
endmodule

// File: rtl/pfd_abp.sv
module pfd_abp #(
    parameter int SEL_W = pfd_pkg::ABP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [SEL_W-1:0] abp_sel,
    output logic             up,
    output logic             dn
);
    localparam int NCH = pfd_pkg::N_CH;

    logic [NCH-1:0] edges;
    logic [NCH-1:0] flags;
    logic           both;
    logic           done;

    assign edges = {fb_pulse, ref_pulse};
    assign both  = &flags;

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        pfd_edge_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .edge_i (edges[i]),
            .both_i (both),
            .done_i (done),
            .flag_o (flags[i])
        );
    end

    pfd_clear_timer #(.SEL_W(SEL_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .both_i (both),
        .sel_i  (abp_sel),
        .done_o (done)
    );

    assign up = flags[0];
    assign dn = flags[1];
endmodule

// File: rtl/pfd_abp_chk.sv
module pfd_abp_chk (
    input logic clk,
    input logic rst,
    input logic ref_pulse,
    input logic fb_pulse,
    input logic up,
    input logic dn
);
    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    // R1
    reset_clears_chk: assert property (@(posedge clk) started && rst |=> !up && !dn);

    // R2
    up_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ref_pulse && !up |=> up);

    // R3
    dn_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fb_pulse && !dn |=> dn);

    // R2
    up_holds_chk: assert property (@(posedge clk) disable iff (rst)
        started && up && !dn |=> up);

    // R4
    up_falls_with_dn_chk: assert property (@(posedge clk) disable iff (rst)
        started && up && !$past(rst) |=> up || $past(dn));

    // R4
    dn_falls_with_up_chk: assert property (@(posedge clk) disable iff (rst)
        started && dn && !$past(rst) |=> dn || $past(up));

    // R6
    held_ref_chk: assert property (@(posedge clk) disable iff (rst)
        up && dn && ref_pulse |=> up);

    // R6
    held_fb_chk: assert property (@(posedge clk) disable iff (rst)
        up && dn && fb_pulse |=> dn);
endmodule

bind pfd_abp pfd_abp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .up        (up),
    .dn        (dn)
);

// File: tb/pfd_abp_bench.sv
module pfd_abp_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic       fb_pulse = 1'b0;
    logic [1:0] abp_sel = 2'b00;
    logic       up, dn;

    int vectors = 0;
    int errors  = 0;

    // expected-behaviour state built from the requirements
    logic m_up, m_dn, m_hr, m_hf;
    int   m_ov;

    always #2 clk = ~clk;

    pfd_abp u_pfd_abp (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .abp_sel(abp_sel), .up(up), .dn(dn)
    );

    task automatic check(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // one clock: drive, advance the model, compare at the negative edge
    task automatic step(input logic r, input logic f, input logic rs);
        logic n_up, n_dn;
        int   d;
        ref_pulse = r; fb_pulse = f; rst = rs;
        @(posedge clk);
        d = int'(abp_sel) + 1;                       // R5
        if (rs) begin
            m_up = 0; m_dn = 0; m_hr = 0; m_hf = 0; m_ov = 0;   // R1
        end else if (m_up && m_dn) begin
            m_ov++;
            if (m_ov == d) begin                     // R4: overlap of D cycles
                n_up = m_hr | r; n_dn = m_hf | f;    // R6
                m_up = n_up; m_dn = n_dn; m_hr = 0; m_hf = 0; m_ov = 0;
            end else begin
                m_hr |= r; m_hf |= f;
            end
        end else begin
            m_up |= r; m_dn |= f;                    // R2 R3
            m_ov = 0;
        end
        @(negedge clk);
        check(up, m_up, rs ? "R1 up" : "R2 up");
        check(dn, m_dn, rs ? "R1 dn" : "R3 dn");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    // pulse pair with fb delayed by k cycles; measure widths
    task automatic pair(input int k, input string req, input int exp_up, input int exp_dn);
        int wu = 0, wd = 0;
        for (int i = 0; i < k + 8; i++) begin
            step(i == 0, i == k, 0);
            wu += up; wd += dn;
        end
        check_int(wu, exp_up, {req, " up width"});
        check_int(wd, exp_dn, {req, " dn width"});
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 1);
        step(1, 1, 1);                                // R1: reset wins over pulses
        step(0, 0, 0);
        check(up, 0, "R1 up after reset");
        check(dn, 0, "R1 dn after reset");

        // R7 R5: in-phase pairs for every code
        for (int s = 0; s < 4; s++) begin
            abp_sel = 2'(s);
            pair(0, "R7", s + 1, s + 1);
        end
        // R8: lead by k
        for (int s = 0; s < 4; s++) begin
            abp_sel = 2'(s);
            pair(3, "R8", 3 + s + 1, s + 1);
        end

        // R2: repeated ref pulses ignored while dn low
        abp_sel = 2'd1;
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        check(up, 1, "R2 up held");
        step(0, 1, 0); idle(4);

        // R6: edge during overlap is kept
        abp_sel = 2'd3;
        step(1, 1, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
        check(up, 1, "R6 held ref re-arms up");
        check(dn, 0, "R6 dn cleared");
        step(0, 1, 0); idle(6);

        // R1: reset in the middle of an overlap with a held edge
        step(1, 1, 0); step(0, 1, 0); step(0, 0, 1); step(0, 0, 0);
        check(dn, 0, "R1 held edge discarded");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            if (!up && !dn && ($urandom % 8 == 0)) abp_sel = 2'($urandom);
            step(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 300) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule